// File: doc/BRIEF.md
# Lazy Random-Fill Data Memory

This block is a word-addressed data store for a processor cross-check environment, where one design and a reference model run side by side and each gets its own copy of the memory. No location holds valid contents at the start. Writes store data as usual. When a location that has never been touched is read, the block makes up a pseudo-random word, returns it, and keeps it. Later reads of that location therefore return the same word.

The random words come from a seeded linear feedback shift register. The register advances only when a fill happens, so the values depend only on the order of accesses. Two copies built with the same seed give the same read data whenever they receive the same ordered access stream, even if one copy runs at a different pace in wall-clock terms.

A requester raises a one-cycle request with address, write flag, byte strobes and write data. The block answers with a single acknowledge pulse on the next cycle and puts read data on its output in that cycle.

Top module: `lazy_fill_mem`

## Requirements
- R1: A synchronous reset, held for at least one clock, marks every location as never accessed. Output `ack_o` is 0 and `rdata_o` is 0 while reset is held and until the first request.
- R2: A request sampled at clock edge t produces `ack_o` = 1 for exactly the cycle after edge t. If no request is sampled at an edge, `ack_o` is 0 in the following cycle.
- R3: After a write with all four strobes set, a read of the same location returns the written word.
- R4: The random generator is a 32-bit register loaded with SEED on reset (a SEED of 0 is replaced by 1). A fill uses the current register value and then advances it: next = (s >> 1) XOR (s[0] ? 32'h80200003 : 0). A read of a never-accessed location returns that fill value.
- R5: A location filled by a read keeps its fill value. Repeated reads return the same word.
- R6: The generator advances once per fill and on no other access. Reads of accessed locations and full-strobe writes leave it unchanged.
- R7: A write whose strobes are not all set, sent to a never-accessed word, takes one fill value. Byte lane k (bits 8k+7:8k) comes from the write data where strobe bit k is 1 and from the fill value where it is 0.
- R8: A write whose strobes are not all set, sent to an already accessed word, changes only the lanes whose strobe bit is 1.
- R9: The location used is the address modulo DEPTH (DEPTH is a power of two). Addresses a and a + DEPTH name the same word.
- R10: Two instances with the same SEED, given the same ordered request stream, return identical read data.
- R11: In the acknowledge cycle of a write, `rdata_o` is 0.
- R12: A reset after activity discards all stored words and reloads the generator, so the first fill after reset again returns SEED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address, wrapped modulo DEPTH |
| be_i | input | 4 | Byte strobes for writes, bit k selects lane k |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Acknowledge, one cycle after the request |
| rdata_o | output | 32 | Read data, valid while ack_o is high on reads |

## Verification
The assertions assume that the requester drives `req_i` and the fields beside it only as whole-cycle values and never leaves them unknown once reset has been released. They also assume that `req_i` is low whenever reset is high. The bench drives all inputs on the falling edge, lowers the request at the falling edge after its acknowledge, and keeps the request low while it pulses reset. The twin instance gets the same signals, so the shared-seed property is checked against exactly the same stream.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;
  localparam logic [WORD_W-1:0] LFSR_TAPS = 32'h80200003;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_HIT   = 2'd2,
    ACC_FILL  = 2'd3
  } acc_kind_t;

  function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
    lfsr_step = (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
  endfunction

  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] base,
    input logic [WORD_W-1:0] upd,
    input logic [LANES-1:0]  sel
  );
    logic [WORD_W-1:0] r;
    r = base;
    for (int k = 0; k < LANES; k++) begin
      if (sel[k]) r[k*LANE_W +: LANE_W] = upd[k*LANE_W +: LANE_W];
    end
    lane_merge = r;
  endfunction
endpackage

// File: rtl/lfm_lfsr.sv
module lfm_lfsr
  import lfm_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED = 32'h1ACE5EED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W-1:0] START = (SEED == '0) ? {{(WORD_W-1){1'b0}}, 1'b1} : SEED;

  logic [WORD_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst)        state_q <= START;
    else if (adv_i) state_q <= lfsr_step(state_q);
  end

  assign word_o = state_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(state_q));
  p_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/lfm_valid_tbl.sv
module lfm_valid_tbl #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_i,
  output logic             seen_o
);
  logic [DEPTH-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst)        seen_q <= '0;
    else if (set_i) seen_q[idx_i] <= 1'b1;
  end

  assign seen_o = seen_q[idx_i];

  p_clear_r1: assert property (@(posedge clk)
    rst |=> (seen_q == '0));
  p_mark_r5: assert property (@(posedge clk) disable iff (rst)
    set_i |=> seen_q[$past(idx_i)]);
endmodule

// File: rtl/lfm_ram.sv
module lfm_ram
  import lfm_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (en_i) begin
        if (lane_we_i[k]) mem[idx_i] <= wdata_i[k*LANE_W +: LANE_W];
        q <= mem[idx_i];
      end
    end

    assign rdata_o[k*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/lazy_fill_mem.sv
module lazy_fill_mem
  import lfm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH = 256,
  parameter logic [31:0] SEED = 32'h1ACE5EED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic              ack_o,
  output logic [31:0]       rdata_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [LANES-1:0] ALL_LANES = '1;

  logic [IDX_W-1:0]  idx;
  logic              seen;
  logic              full_wr;
  logic              do_fill;
  logic [WORD_W-1:0] rand_word;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] ram_wdata;
  logic [WORD_W-1:0] ram_q;
  acc_kind_t         kind_d, kind_q;
  logic [WORD_W-1:0] fill_q;
  logic              ack_q;

  assign idx     = addr_i[IDX_W-1:0];
  assign full_wr = (be_i == ALL_LANES);
  assign do_fill = req_i && !seen && (!we_i || !full_wr);

  lfm_valid_tbl #(.DEPTH(DEPTH)) u_seen (
    .clk    (clk),
    .rst    (rst),
    .idx_i  (idx),
    .set_i  (req_i),
    .seen_o (seen)
  );

  lfm_lfsr #(.SEED(SEED)) u_rand (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (do_fill),
    .word_o (rand_word)
  );

  always_comb begin
    lane_we   = '0;
    ram_wdata = rand_word;
    kind_d    = ACC_IDLE;
    if (req_i) begin
      if (we_i) begin
        kind_d = ACC_WRITE;
        if (seen) begin
          lane_we   = be_i;
          ram_wdata = wdata_i;
        end else begin
          lane_we   = ALL_LANES;
          ram_wdata = lane_merge(rand_word, wdata_i, be_i);
        end
      end else if (seen) begin
        kind_d = ACC_HIT;
      end else begin
        kind_d  = ACC_FILL;
        lane_we = ALL_LANES;
      end
    end
  end

  lfm_ram #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .en_i      (req_i),
    .lane_we_i (lane_we),
    .idx_i     (idx),
    .wdata_i   (ram_wdata),
    .rdata_o   (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      kind_q <= ACC_IDLE;
      fill_q <= '0;
    end else begin
      ack_q  <= req_i;
      kind_q <= kind_d;
      if (kind_d == ACC_FILL) fill_q <= rand_word;
    end
  end

  assign ack_o = ack_q;

  always_comb begin
    case (kind_q)
      ACC_HIT:  rdata_o = ram_q;
      ACC_FILL: rdata_o = fill_q;
      default:  rdata_o = '0;
    endcase
  end

  p_ack_after_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_i |=> ack_o);
  p_no_stray_ack_r2: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !ack_o);
  p_write_ack_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (req_i && we_i) |=> (rdata_o == '0));
  p_fill_moves_rand_r6: assert property (@(posedge clk) disable iff (rst)
    do_fill |=> (rand_word != $past(rand_word)));
  p_full_write_keeps_rand_r6: assert property (@(posedge clk) disable iff (rst)
    (req_i && we_i && full_wr) |=> $stable(rand_word));
endmodule

// File: tb/tb_lazy_fill_mem.sv
module tb_lazy_fill_mem;
  localparam int DEPTH = 64;
  localparam int ADDR_W = 16;
  localparam logic [31:0] TB_SEED = 32'h1ACE5EED;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wd = '0;
  logic ack, ack2;
  logic [31:0] rd, rd2;

  int checks = 0;
  int errors = 0;

  logic [31:0] mm [DEPTH];
  logic        mv [DEPTH];
  logic [31:0] ms;

  always #5ns clk = ~clk;

  lazy_fill_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SEED(TB_SEED)) dut (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wd), .ack_o(ack), .rdata_o(rd));

  lazy_fill_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SEED(TB_SEED)) twin (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wd), .ack_o(ack2), .rdata_o(rd2));

  function automatic logic [31:0] step(input logic [31:0] s);
    step = (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      mv[i] = 1'b0;
      mm[i] = '0;
    end
    ms = TB_SEED;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    req = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic access(input logic w, input int a, input logic [3:0] s,
                        input logic [31:0] d, input string tag,
                        output logic [31:0] got);
    int i;
    logic [31:0] exp, base;
    i = a % DEPTH;
    if (!w) begin
      if (mv[i]) exp = mm[i];
      else begin
        exp = ms; mm[i] = ms; mv[i] = 1'b1; ms = step(ms);
      end
    end else begin
      exp = '0;
      if (!mv[i] && s != 4'hF) begin
        base = ms; ms = step(ms);
      end else base = mm[i];
      for (int k = 0; k < 4; k++) if (s[k]) base[k*8 +: 8] = d[k*8 +: 8];
      mm[i] = base; mv[i] = 1'b1;
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = ADDR_W'(a); be = s; wd = d;
    @(negedge clk);
    req = 1'b0;
    got = rd;
    check({tag, " R2 ack"}, {31'b0, ack}, 32'd1);
    check(w ? {tag, " R11 write data"} : tag, rd, exp);
    check({tag, " R10 twin"}, rd2, rd);
  endtask

  task automatic t_reset_state();
    logic [31:0] g;
    check("R1 ack idle after reset", {31'b0, ack}, 32'd0);
    check("R1 rdata idle after reset", rd, 32'd0);
    access(1'b0, 5, 4'h0, 0, "R1 first read is fill", g);
    check("R4 first fill equals seed", g, TB_SEED);
  endtask

  task automatic t_ack_idle();
    @(negedge clk);
    check("R2 no ack without request", {31'b0, ack}, 32'd0);
  endtask

  task automatic t_full_write();
    logic [31:0] g;
    for (int i = 10; i < 18; i++) access(1'b1, i, 4'hF, 32'hC0DE0000 + i, "R3 write", g);
    for (int i = 10; i < 18; i++) access(1'b0, i, 4'h0, 0, "R3 read back", g);
  endtask

  task automatic t_miss_sequence();
    logic [31:0] g;
    for (int i = 20; i < 26; i++) access(1'b0, i, 4'h0, 0, "R4 miss sequence", g);
  endtask

  task automatic t_repeat();
    logic [31:0] g1, g2;
    access(1'b0, 30, 4'h0, 0, "R5 fill", g1);
    access(1'b0, 30, 4'h0, 0, "R5 reread", g2);
    check("R5 same word", g2, g1);
  endtask

  task automatic t_no_advance();
    logic [31:0] g;
    logic [31:0] expect_next;
    expect_next = ms;
    access(1'b0, 10, 4'h0, 0, "R6 hit", g);
    access(1'b1, 31, 4'hF, 32'h12345678, "R6 full write new", g);
    access(1'b1, 10, 4'hF, 32'h0BADF00D, "R6 full write old", g);
    access(1'b0, 32, 4'h0, 0, "R6 next miss", g);
    check("R6 generator untouched", g, expect_next);
  endtask

  task automatic t_partial_miss();
    logic [31:0] g, fillv;
    fillv = ms;
    access(1'b1, 40, 4'b0101, 32'hAABBCCDD, "R7 partial write new", g);
    access(1'b0, 40, 4'h0, 0, "R7 merged word", g);
    check("R7 lane mix", g, {fillv[31:24], 8'hBB, fillv[15:8], 8'hDD});
    access(1'b0, 41, 4'h0, 0, "R7 fill consumed", g);
    check("R7 next fill", g, step(fillv));
  endtask

  task automatic t_partial_hit();
    logic [31:0] g;
    access(1'b1, 42, 4'hF, 32'h11223344, "R8 setup", g);
    access(1'b1, 42, 4'b1010, 32'h99887766, "R8 partial write", g);
    access(1'b0, 42, 4'h0, 0, "R8 read", g);
    check("R8 lanes", g, 32'h99227744);
  endtask

  task automatic t_wrap();
    logic [31:0] g;
    access(1'b1, 3, 4'hF, 32'hFEEDBEEF, "R9 write low", g);
    access(1'b0, 3 + DEPTH, 4'h0, 0, "R9 read aliased", g);
    check("R9 alias", g, 32'hFEEDBEEF);
  endtask

  task automatic t_reset_mid();
    logic [31:0] g;
    pulse_reset();
    access(1'b0, 3, 4'h0, 0, "R12 read after reset", g);
    check("R12 seed again", g, TB_SEED);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    model_reset();
    pulse_reset();
    t_reset_state();
    t_ack_idle();
    t_full_write();
    t_miss_sequence();
    t_repeat();
    t_no_advance();
    t_partial_miss();
    t_partial_hit();
    t_wrap();
    t_ack_idle();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule